// File: doc/BRIEF.md
# Device Error Signaling Controller

This block sits inside one PCI Express function and handles one detected error at a time. An error arrives as a single-cycle strobe carrying a status vector and two flags (correctable, possibly advisory). The block keeps only the supported bits of the vector and requires exactly one of them to remain. It then chooses a handling path: correctable, advisory non-fatal, or uncorrectable.

On that path it sets sticky bits in three status registers: correctable status, uncorrectable status, and a four-bit detected-error summary. It decides, using the mask, severity and reporting-enable inputs and the system-error override, whether an upstream error message is raised and with which severity code. It asks an external header-log unit to record uncorrectable errors. If that unit reports that its queue has overflowed, the block raises a follow-up correctable header-log-overflow error through the same correctable path, one cycle later.

The configuration decoder that owns the mask, severity and enable registers is outside this block, and so are the header storage and the link layer. All three status registers only set bits. They return to zero on reset.

Top module: `err_signal_ctrl`

## Requirements
- R1: An accepted error has its status ANDed with the supported set: correctable 0x0000F1C1, uncorrectable 0x03FFD010. If zero bits or more than one bit remain, the error changes no status, raises no message and requests no log.
- R2: A correctable error sets `det_flags` bit 0 and its own bit in `cor_status`. When it is unmasked and `cfg_cor_rep_en` is 1, `msg_valid` pulses for one cycle with `msg_sev` = 1. The results are visible in the cycle after the strobe.
- R3: A correctable error whose bit is set in `cfg_cor_mask` updates `det_flags` and `cor_status` only. It raises no message.
- R4: A correctable-path message is suppressed when `cfg_cor_rep_en` is 0. If the error came from an uncorrectable unsupported request (bit 20), it is also suppressed when `cfg_ur_rep_en` is 0.
- R5: For an uncorrectable error, its bit in `cfg_unc_sev` selects fatal (1) or non-fatal (0). Fatal sets `det_flags` bit 2 and non-fatal sets bit 1. If the error is unmasked, `log_req` pulses with `log_status` equal to the error bit.
- R6: An uncorrectable error whose bit is set in `cfg_unc_mask` sets its `unc_status` bit and its `det_flags` severity bit. It raises no message and no log request.
- R7: A fatal message (`msg_sev` = 3) needs `cfg_serr_en` or `cfg_fatal_rep_en`. A non-fatal message (`msg_sev` = 2) needs `cfg_serr_en` or `cfg_nf_rep_en`.
- R8: An uncorrectable unsupported request (bit 20) sets `det_flags` bit 3. Its message is suppressed when both `cfg_ur_rep_en` and `cfg_serr_en` are 0.
- R9: A non-fatal uncorrectable error with `evt_maybe_adv` set is handled as correctable advisory bit 13. If bit 13 is unmasked in `cfg_cor_mask`, the original bit is also set in `unc_status` and the message is sent with `msg_sev` = 1. The log request is raised only when the original bit is unmasked in `cfg_unc_mask`. A fatal error with the flag follows the uncorrectable path.
- R10: If `log_ovf` is high while `log_req` is high, `busy` is high in the next cycle. In the cycle after that, a correctable error on bit 15 takes effect. An external strobe during the `busy` cycle is dropped.
- R11: With `USE_SEV_REG` = 0, severity ignores `cfg_unc_sev`. Bits 4, 17, 18 and 22 are fatal and every other supported bit is non-fatal.
- R12: After reset, all status outputs, `msg_valid`, `log_req` and `busy` are 0. Status bits stay set across later errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Single-cycle error strobe |
| evt_status | input | 32 | Error status vector, one bit expected |
| evt_is_cor | input | 1 | Error is correctable |
| evt_maybe_adv | input | 1 | Uncorrectable error may be treated as advisory |
| cfg_unc_mask | input | 32 | Uncorrectable mask |
| cfg_unc_sev | input | 32 | Uncorrectable severity, 1 = fatal |
| cfg_cor_mask | input | 32 | Correctable mask |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Non-fatal reporting enable |
| cfg_fatal_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| cfg_serr_en | input | 1 | System-error override enable |
| log_ovf | input | 1 | Header-log queue overflow, valid while log_req is high |
| busy | output | 1 | Overflow follow-up in progress; strobes are dropped |
| cor_status | output | 32 | Sticky correctable status |
| unc_status | output | 32 | Sticky uncorrectable status |
| det_flags | output | 4 | Sticky summary: 0 corr, 1 non-fatal, 2 fatal, 3 unsupported request |
| msg_valid | output | 1 | Upstream message pulse |
| msg_sev | output | 2 | Message severity: 1 corr, 2 non-fatal, 3 fatal |
| log_req | output | 1 | Header-log record request |
| log_status | output | 32 | Error bit to record |

## Verification
Every status, message and log result of a strobe is registered once, so it is due in the cycle directly after the strobe. The bench drives each strobe at a falling edge, removes it at the next falling edge, and samples all outputs there. The message pulse is checked again one cycle later to confirm that it has dropped. The overflow follow-up spans two more cycles: `busy` is due one cycle after the log request, and the header-log-overflow bit and its message are due one cycle after that. The bench samples each cycle of this sequence separately and places a competing strobe in the busy cycle.

// File: rtl/err_sig_pkg.sv
`timescale 1ns/1ps
package err_sig_pkg;
  localparam int STW = 32;
  localparam int DFW = 4;

  localparam logic [STW-1:0] COR_SUPPORTED     = 32'h0000_F1C1;
  localparam logic [STW-1:0] UNC_SUPPORTED     = 32'h03FF_D010;
  localparam logic [STW-1:0] UNC_FATAL_DEFAULT = 32'h0046_0010;

  localparam int UR_BIT    = 20;
  localparam int ADV_BIT   = 13;
  localparam int HLOVF_BIT = 15;

  localparam int DF_COR   = 0;
  localparam int DF_NF    = 1;
  localparam int DF_FATAL = 2;
  localparam int DF_UR    = 3;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'd0,
    SEV_COR      = 2'd1,
    SEV_NONFATAL = 2'd2,
    SEV_FATAL    = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    PATH_COR = 2'd0,
    PATH_ADV = 2'd1,
    PATH_UNC = 2'd2
  } path_e;

  function automatic logic single_bit(input logic [STW-1:0] v);
    return (v != '0) && ((v & (v - STW'(1))) == '0);
  endfunction

  function automatic logic [STW-1:0] bit_at(input int pos);
    return STW'(1) << pos;
  endfunction
endpackage

// File: rtl/err_sig_classify.sv
`timescale 1ns/1ps
module err_sig_classify
  import err_sig_pkg::*;
#(
  parameter bit USE_SEV_REG = 1'b1
) (
  input  logic [STW-1:0] status,
  input  logic           is_cor,
  input  logic           maybe_adv,
  input  logic [STW-1:0] sev_reg,
  output logic           ok,
  output logic [STW-1:0] bitv,
  output path_e          path,
  output logic           fatal,
  output logic           ur
);
  logic [STW-1:0] sev_src;

  generate
    if (USE_SEV_REG) begin : g_sev_reg
      assign sev_src = sev_reg;
    end else begin : g_sev_fixed
      assign sev_src = UNC_FATAL_DEFAULT;
    end
  endgenerate

  always_comb begin
    bitv  = status & (is_cor ? COR_SUPPORTED : UNC_SUPPORTED);
    ok    = single_bit(bitv);
    fatal = !is_cor && ((bitv & sev_src) != '0);
    ur    = !is_cor && bitv[UR_BIT];
    if (is_cor)                 path = PATH_COR;
    else if (!fatal && maybe_adv) path = PATH_ADV;
    else                        path = PATH_UNC;
  end
endmodule

// File: rtl/err_sig_gate.sv
`timescale 1ns/1ps
module err_sig_gate
  import err_sig_pkg::*;
(
  input  path_e          path,
  input  logic [STW-1:0] bitv,
  input  logic           fatal,
  input  logic           ur,
  input  logic [STW-1:0] cor_mask,
  input  logic [STW-1:0] unc_mask,
  input  logic           cor_en,
  input  logic           nf_en,
  input  logic           fatal_en,
  input  logic           ur_en,
  input  logic           serr_en,
  output logic [STW-1:0] cor_set,
  output logic [STW-1:0] unc_set,
  output logic [DFW-1:0] df_set,
  output logic           log_fire,
  output logic           msg_fire,
  output sev_e           msg_code
);
  logic [STW-1:0] cor_bit;
  logic           unc_masked;

  always_comb begin
    cor_bit    = (path == PATH_ADV) ? bit_at(ADV_BIT) : bitv;
    unc_masked = (unc_mask & bitv) != '0;
    cor_set    = '0;
    unc_set    = '0;
    df_set     = '0;
    log_fire   = 1'b0;
    msg_fire   = 1'b0;
    msg_code   = SEV_NONE;
    df_set[DF_UR] = ur;
    case (path)
      PATH_COR, PATH_ADV: begin
        df_set[DF_COR] = 1'b1;
        cor_set        = cor_bit;
        if ((cor_mask & cor_bit) == '0) begin
          if (path == PATH_ADV) begin
            unc_set  = bitv;
            log_fire = !unc_masked;
          end
          if (cor_en && !(ur && !ur_en)) begin
            msg_fire = 1'b1;
            msg_code = SEV_COR;
          end
        end
      end
      PATH_UNC: begin
        if (fatal) df_set[DF_FATAL] = 1'b1;
        else       df_set[DF_NF]    = 1'b1;
        unc_set = bitv;
        if (!unc_masked) begin
          log_fire = 1'b1;
          if (!(ur && !ur_en && !serr_en)) begin
            if (fatal && (serr_en || fatal_en)) begin
              msg_fire = 1'b1;
              msg_code = SEV_FATAL;
            end else if (!fatal && (serr_en || nf_en)) begin
              msg_fire = 1'b1;
              msg_code = SEV_NONFATAL;
            end
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/err_signal_ctrl.sv
`timescale 1ns/1ps
module err_signal_ctrl
  import err_sig_pkg::*;
#(
  parameter bit USE_SEV_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic [31:0]             evt_status,
  input  logic                    evt_is_cor,
  input  logic                    evt_maybe_adv,
  input  logic [31:0]             cfg_unc_mask,
  input  logic [31:0]             cfg_unc_sev,
  input  logic [31:0]             cfg_cor_mask,
  input  logic                    cfg_cor_rep_en,
  input  logic                    cfg_nf_rep_en,
  input  logic                    cfg_fatal_rep_en,
  input  logic                    cfg_ur_rep_en,
  input  logic                    cfg_serr_en,
  input  logic                    log_ovf,
  output logic                    busy,
  output logic [31:0]             cor_status,
  output logic [31:0]             unc_status,
  output logic [3:0]              det_flags,
  output logic                    msg_valid,
  output logic [1:0]              msg_sev,
  output logic                    log_req,
  output logic [31:0]             log_status
);
  // follow-up overflow pending; takes the event slot for one cycle
  logic           ovf_pend;

  // selected event source
  logic           src_valid;
  logic [STW-1:0] src_status;
  logic           src_cor;
  logic           src_adv;

  // classifier results
  logic           cls_ok;
  logic [STW-1:0] cls_bit;
  path_e          cls_path;
  logic           cls_fatal;
  logic           cls_ur;

  // gate results
  logic [STW-1:0] g_cor_set;
  logic [STW-1:0] g_unc_set;
  logic [DFW-1:0] g_df_set;
  logic           g_log;
  logic           g_msg;
  sev_e           g_code;

  // named internal event: an error that updates state this cycle
  logic           evt_ok;

  assign src_valid  = ovf_pend || evt_valid;
  assign src_status = ovf_pend ? bit_at(HLOVF_BIT) : evt_status;
  assign src_cor    = ovf_pend || evt_is_cor;
  assign src_adv    = !ovf_pend && evt_maybe_adv;

  err_sig_classify #(.USE_SEV_REG(USE_SEV_REG)) u_cls (
    .status    (src_status),
    .is_cor    (src_cor),
    .maybe_adv (src_adv),
    .sev_reg   (cfg_unc_sev),
    .ok        (cls_ok),
    .bitv      (cls_bit),
    .path      (cls_path),
    .fatal     (cls_fatal),
    .ur        (cls_ur)
  );

  err_sig_gate u_gate (
    .path      (cls_path),
    .bitv      (cls_bit),
    .fatal     (cls_fatal),
    .ur        (cls_ur),
    .cor_mask  (cfg_cor_mask),
    .unc_mask  (cfg_unc_mask),
    .cor_en    (cfg_cor_rep_en),
    .nf_en     (cfg_nf_rep_en),
    .fatal_en  (cfg_fatal_rep_en),
    .ur_en     (cfg_ur_rep_en),
    .serr_en   (cfg_serr_en),
    .cor_set   (g_cor_set),
    .unc_set   (g_unc_set),
    .df_set    (g_df_set),
    .log_fire  (g_log),
    .msg_fire  (g_msg),
    .msg_code  (g_code)
  );

  assign evt_ok = src_valid && cls_ok;

  sev_e sev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pend   <= 1'b0;
      cor_status <= '0;
      unc_status <= '0;
      det_flags  <= '0;
      msg_valid  <= 1'b0;
      sev_q      <= SEV_NONE;
      log_req    <= 1'b0;
      log_status <= '0;
    end else begin
      ovf_pend  <= log_req && log_ovf;
      msg_valid <= evt_ok && g_msg;
      sev_q     <= (evt_ok && g_msg) ? g_code : SEV_NONE;
      log_req   <= evt_ok && g_log;
      log_status <= (evt_ok && g_log) ? cls_bit : '0;
      if (evt_ok) begin
        cor_status <= cor_status | g_cor_set;
        unc_status <= unc_status | g_unc_set;
        det_flags  <= det_flags  | g_df_set;
      end
    end
  end

  assign msg_sev = sev_q;
  assign busy    = ovf_pend;
endmodule

// File: rtl/err_sig_chk.sv
`timescale 1ns/1ps
module err_sig_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_ok,
  input logic        busy,
  input logic [31:0] cor_status,
  input logic [31:0] unc_status,
  input logic [3:0]  det_flags,
  input logic        msg_valid,
  input logic [1:0]  msg_sev,
  input logic        log_req,
  input logic [31:0] log_status
);
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ok |=> ($stable(cor_status) && $stable(unc_status) &&
                 $stable(det_flags) && !msg_valid && !log_req));

  p_msg_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'd0));

  p_cor_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd1) |-> det_flags[0]);

  p_fatal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3) |-> det_flags[2]);

  p_log_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(log_status) == 1 && (unc_status & log_status) != 32'd0));

  p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cor_status[15] && det_flags[0] && !busy));

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cor_status & $past(cor_status)) == $past(cor_status)) &&
              ((unc_status & $past(unc_status)) == $past(unc_status)) &&
              ((det_flags  & $past(det_flags))  == $past(det_flags))));
endmodule

bind err_signal_ctrl err_sig_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_ok     (evt_ok),
  .busy       (busy),
  .cor_status (cor_status),
  .unc_status (unc_status),
  .det_flags  (det_flags),
  .msg_valid  (msg_valid),
  .msg_sev    (msg_sev),
  .log_req    (log_req),
  .log_status (log_status)
);

// File: tb/tb_err_signal_ctrl.sv
`timescale 1ns/1ps
module tb_err_signal_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [31:0] evt_status = '0;
  logic        evt_is_cor = 1'b0;
  logic        evt_maybe_adv = 1'b0;
  logic [31:0] cfg_unc_mask, cfg_unc_sev, cfg_cor_mask;
  logic        cfg_cor_rep_en, cfg_nf_rep_en, cfg_fatal_rep_en, cfg_ur_rep_en, cfg_serr_en;
  logic        ovf_mode = 1'b0;
  logic        log_ovf;

  logic        busy, msg_valid, log_req;
  logic [31:0] cor_status, unc_status, log_status;
  logic [3:0]  det_flags;
  logic [1:0]  msg_sev;

  logic        fx_busy, fx_msg_valid, fx_log_req;
  logic [31:0] fx_cor_status, fx_unc_status, fx_log_status;
  logic [3:0]  fx_det_flags;
  logic [1:0]  fx_msg_sev;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  // header-log unit model: overflow answered while a request is present
  assign log_ovf = log_req && ovf_mode;

  err_signal_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
    .evt_is_cor(evt_is_cor), .evt_maybe_adv(evt_maybe_adv),
    .cfg_unc_mask(cfg_unc_mask), .cfg_unc_sev(cfg_unc_sev), .cfg_cor_mask(cfg_cor_mask),
    .cfg_cor_rep_en(cfg_cor_rep_en), .cfg_nf_rep_en(cfg_nf_rep_en),
    .cfg_fatal_rep_en(cfg_fatal_rep_en), .cfg_ur_rep_en(cfg_ur_rep_en),
    .cfg_serr_en(cfg_serr_en), .log_ovf(log_ovf), .busy(busy),
    .cor_status(cor_status), .unc_status(unc_status), .det_flags(det_flags),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .log_req(log_req), .log_status(log_status)
  );

  err_signal_ctrl #(.USE_SEV_REG(1'b0)) dut_fx (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
    .evt_is_cor(evt_is_cor), .evt_maybe_adv(evt_maybe_adv),
    .cfg_unc_mask(cfg_unc_mask), .cfg_unc_sev(cfg_unc_sev), .cfg_cor_mask(cfg_cor_mask),
    .cfg_cor_rep_en(cfg_cor_rep_en), .cfg_nf_rep_en(cfg_nf_rep_en),
    .cfg_fatal_rep_en(cfg_fatal_rep_en), .cfg_ur_rep_en(cfg_ur_rep_en),
    .cfg_serr_en(cfg_serr_en), .log_ovf(1'b0), .busy(fx_busy),
    .cor_status(fx_cor_status), .unc_status(fx_unc_status), .det_flags(fx_det_flags),
    .msg_valid(fx_msg_valid), .msg_sev(fx_msg_sev), .log_req(fx_log_req),
    .log_status(fx_log_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    cfg_unc_mask = '0;
    cfg_cor_mask = '0;
    cfg_unc_sev  = 32'h0046_0010;
    cfg_cor_rep_en = 1; cfg_nf_rep_en = 1; cfg_fatal_rep_en = 1;
    cfg_ur_rep_en = 1;  cfg_serr_en = 0;
    ovf_mode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cfg_default();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // strobe at a falling edge, drop it at the next; results are sampled then
  task automatic fire(input logic [31:0] st, input logic cor, input logic adv);
    @(negedge clk);
    evt_valid = 1; evt_status = st; evt_is_cor = cor; evt_maybe_adv = adv;
    @(negedge clk);
    evt_valid = 0; evt_status = '0; evt_is_cor = 0; evt_maybe_adv = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 cor_status reset", cor_status, 0);
    chk("R12 unc_status reset", unc_status, 0);
    chk("R12 det_flags reset", {28'd0, det_flags}, 0);
    chk("R12 msg/log/busy reset", {29'd0, msg_valid, log_req, busy}, 0);
  endtask

  task automatic t_reject();
    do_reset();
    fire(32'h0, 0, 0);
    chk("R1 zero bits msg/log", {30'd0, msg_valid, log_req}, 0);
    fire(32'h0000_1010, 0, 0);
    chk("R1 two bits unc_status", unc_status, 0);
    fire(32'h0000_0020, 0, 0);
    chk("R1 unsupported bit det_flags", {28'd0, det_flags}, 0);
    fire(32'h0000_6000, 1, 0);
    chk("R1 two cor bits cor_status", cor_status, 0);
    chk("R1 two cor bits msg", {31'd0, msg_valid}, 0);
  endtask

  task automatic t_cor();
    do_reset();
    fire(32'h0000_0040, 1, 0);
    chk("R2 cor msg_valid", {31'd0, msg_valid}, 1);
    chk("R2 cor msg_sev", {30'd0, msg_sev}, 1);
    chk("R2 cor_status", cor_status, 32'h40);
    chk("R2 det_flags", {28'd0, det_flags}, 4'b0001);
    chk("R2 no log", {31'd0, log_req}, 0);
    @(negedge clk);
    chk("R2 msg pulse ends", {31'd0, msg_valid}, 0);
  endtask

  task automatic t_cor_masked();
    do_reset();
    cfg_cor_mask = 32'h1;
    fire(32'h1, 1, 0);
    chk("R3 masked cor_status", cor_status, 32'h1);
    chk("R3 masked det_flags", {28'd0, det_flags}, 1);
    chk("R3 masked no msg", {31'd0, msg_valid}, 0);
  endtask

  task automatic t_cor_enable();
    do_reset();
    cfg_cor_rep_en = 0;
    fire(32'h80, 1, 0);
    chk("R4 disabled no msg", {31'd0, msg_valid}, 0);
    chk("R4 disabled status", cor_status, 32'h80);
    do_reset();
    cfg_ur_rep_en = 0;
    fire(32'h0010_0000, 0, 1);
    chk("R4 adv UR no msg", {31'd0, msg_valid}, 0);
    chk("R4 adv UR det_flags", {28'd0, det_flags}, 4'b1001);
    chk("R4 adv UR cor_status", cor_status, 32'h2000);
    chk("R4 adv UR log", {31'd0, log_req}, 1);
  endtask

  task automatic t_unc_sev();
    do_reset();
    fire(32'h0004_0000, 0, 0);
    chk("R5 fatal msg_sev", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b111});
    chk("R5 fatal det_flags", {28'd0, det_flags}, 4'b0100);
    chk("R5 log_req", {31'd0, log_req}, 1);
    chk("R5 log_status", log_status, 32'h0004_0000);
    chk("R5 unc_status", unc_status, 32'h0004_0000);
    do_reset();
    cfg_unc_sev = 0;
    fire(32'h0004_0000, 0, 0);
    chk("R5 sev reg nonfatal msg", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b110});
    chk("R5 nonfatal det_flags", {28'd0, det_flags}, 4'b0010);
  endtask

  task automatic t_unc_masked();
    do_reset();
    cfg_unc_mask = 32'h0001_0000;
    fire(32'h0001_0000, 0, 0);
    chk("R6 masked unc_status", unc_status, 32'h0001_0000);
    chk("R6 masked det_flags", {28'd0, det_flags}, 4'b0010);
    chk("R6 masked msg/log", {30'd0, msg_valid, log_req}, 0);
  endtask

  task automatic t_gating();
    do_reset();
    cfg_fatal_rep_en = 0; cfg_nf_rep_en = 0;
    fire(32'h10, 0, 0);
    chk("R7 fatal gated off", {31'd0, msg_valid}, 0);
    chk("R7 fatal gated still logs", {31'd0, log_req}, 1);
    fire(32'h1000, 0, 0);
    chk("R7 nonfatal gated off", {31'd0, msg_valid}, 0);
    cfg_serr_en = 1;
    fire(32'h10, 0, 0);
    chk("R7 serr fatal", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b111});
    fire(32'h1000, 0, 0);
    chk("R7 serr nonfatal", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b110});
  endtask

  task automatic t_ur();
    do_reset();
    cfg_ur_rep_en = 0;
    fire(32'h0010_0000, 0, 0);
    chk("R8 UR suppressed", {31'd0, msg_valid}, 0);
    chk("R8 UR det_flags", {28'd0, det_flags}, 4'b1010);
    chk("R8 UR logged", {31'd0, log_req}, 1);
    cfg_serr_en = 1;
    fire(32'h0010_0000, 0, 0);
    chk("R8 UR with serr", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b110});
    cfg_serr_en = 0; cfg_ur_rep_en = 1;
    fire(32'h0010_0000, 0, 0);
    chk("R8 UR with enable", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b110});
  endtask

  task automatic t_adv();
    do_reset();
    fire(32'h4000, 0, 1);
    chk("R9 adv msg cor", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b101});
    chk("R9 adv cor_status", cor_status, 32'h2000);
    chk("R9 adv unc_status", unc_status, 32'h4000);
    chk("R9 adv det_flags", {28'd0, det_flags}, 4'b0001);
    chk("R9 adv log", log_status, 32'h4000);
    do_reset();
    cfg_unc_mask = 32'h4000;
    fire(32'h4000, 0, 1);
    chk("R9 adv masked no log", {31'd0, log_req}, 0);
    chk("R9 adv masked unc bit", unc_status, 32'h4000);
    do_reset();
    fire(32'h0002_0000, 0, 1);
    chk("R9 fatal adv stays fatal", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b111});
    chk("R9 fatal adv no cor bit", cor_status, 0);
  endtask

  task automatic t_ovf();
    do_reset();
    ovf_mode = 1;
    fire(32'h8000, 0, 0);
    chk("R10 original msg", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b110});
    chk("R10 log_req", {31'd0, log_req}, 1);
    @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 1);
    evt_valid = 1; evt_status = 32'h1; evt_is_cor = 1;
    @(negedge clk);
    evt_valid = 0; evt_status = '0; evt_is_cor = 0;
    chk("R10 follow-up msg", {29'd0, msg_valid, msg_sev}, {29'd0, 3'b101});
    chk("R10 follow-up cor_status", cor_status, 32'h8000);
    chk("R10 busy ends", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R10 dropped event", cor_status, 32'h8000);
    chk("R10 no extra msg", {31'd0, msg_valid}, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    cfg_unc_sev = 0;
    fire(32'h0040_0000, 0, 0);
    chk("R11 fixed fatal", {29'd0, fx_msg_valid, fx_msg_sev}, {29'd0, 3'b111});
    chk("R11 reg variant nonfatal", {30'd0, msg_sev}, 2);
    cfg_unc_sev = 32'hFFFF_FFFF;
    fire(32'h0008_0000, 0, 0);
    chk("R11 fixed nonfatal", {29'd0, fx_msg_valid, fx_msg_sev}, {29'd0, 3'b110});
    chk("R11 reg variant fatal", {30'd0, msg_sev}, 3);
  endtask

  task automatic t_sticky();
    do_reset();
    fire(32'h1, 1, 0);
    fire(32'h1000, 1, 0);
    chk("R12 cor bits accumulate", cor_status, 32'h1001);
    fire(32'h10, 0, 0);
    chk("R12 det_flags accumulate", {28'd0, det_flags}, 4'b0101);
  endtask

  initial begin
    cfg_default();
    t_reset();
    t_reject();
    t_cor();
    t_cor_masked();
    t_cor_enable();
    t_unc_sev();
    t_unc_masked();
    t_gating();
    t_ur();
    t_adv();
    t_ovf();
    t_fixed();
    t_sticky();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule